// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives three half-bridge phases. Each phase has a high-side gate and a low-side gate. A shared counter runs from zero up to a programmed half-period value and back down again, so one switching period lasts twice that value in clocks. Every phase compares the counter with its own duty value. The high side is on while the counter is below the duty value, and the low side takes the other state. One guard-time value sets a window in which both gates of a phase are held low before either gate turns on. This window applies on every complementary transition of all three phases.

Software programs the half-period, the guard time and the three duty values through a plain write port. A written value goes into a holding register first. The holding registers are copied into the working set only when the counter returns to zero, so a period never mixes old and new settings. A one-clock sync pulse marks the start of each period and sets a sticky interrupt request, which software clears with a write. The gate outputs are raw: trip shutdown, chopping and per-output masking are done by a later stage.

Top module: `pwm3_center`

## Requirements
- R1: A write to address 0 (half-period, 16 bits), address 1 (guard time, data bits 9:0), or address 2, 3 or 4 (duty of phase 0, 1 or 2) is held until the next counter wrap to zero. A period that is already running keeps its length and waveforms.
- R2: With a working half-period P of 2 or more, sync_o is high for exactly one clock per period, and consecutive pulses are 2·P clocks apart. The counter sequence is 0, 1 … P, P−1 … 1.
- R3: While the working half-period is 0 or 1, all six gates stay low and sync_o never pulses. The block rechecks the held half-period every clock and restarts as soon as a legal value is written.
- R4: The high-side gate of a phase with duty d is high for 2·d−1−2·G clocks per period when 1 ≤ d ≤ P (G is the guard value, result floored at 0). It is never high for d = 0 and always high for d > P.
- R5: The low-side gate is high for 2·P−2·d+1−2·G clocks per period when 1 ≤ d ≤ P (floored at 0). It is always high for d = 0 and never high for d > P.
- R6: Every turn-on of a gate is preceded by 2·G clocks in which both gates of that phase are low, so each toggling phase spends 4·G clocks per period with both gates low.
- R7: The high-side and low-side gates of a phase are never high in the same clock.
- R8: sync_irq_o is set in the clock in which sync_o is high. A write to address 5 clears it, and a set in the same clock takes priority over the clear.
- R9: After reset all outputs are low, every held and working register is zero, and the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select (0 half-period, 1 guard, 2..4 duty, 5 irq clear) |
| wr_data_i | input | 16 | Write data |
| gate_hi_o | output | 3 | High-side gate per phase |
| gate_lo_o | output | 3 | Low-side gate per phase |
| sync_o | output | 1 | One-clock pulse at the start of each period |
| sync_irq_o | output | 1 | Sticky interrupt request set by sync |

## Verification
Each gate and sync_o appear one clock after the counter value that decides them. A write takes effect at the first wrap after the write edge and shows on sync_o one clock after that. An interrupt clear is visible one clock after its write edge. The reference model in the bench advances on the same edge as the design and keeps this one-clock output register, and all comparisons are made on the falling edge. Width, gap and period measurements run only from the third sync after a reconfiguration, so the guard-time history is already settled for the new settings.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int REG_ADDR_W = 3;
  localparam logic [REG_ADDR_W-1:0] ADDR_HALF    = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_GUARD   = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_DUTY0   = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_IRQ_CLR = 3'd5;
endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
  import pwm3_pkg::*;
#(
  parameter int PHASES = 3,
  parameter int CNT_W  = 16,
  parameter int DT_W   = 10
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [REG_ADDR_W-1:0]         wr_addr_i,
  input  logic [CNT_W-1:0]              wr_data_i,
  input  logic                          load_i,
  output logic [CNT_W-1:0]              shd_half_o,
  output logic [CNT_W-1:0]              act_half_o,
  output logic [DT_W-1:0]               act_guard_o,
  output logic [PHASES-1:0][CNT_W-1:0]  act_duty_o,
  output logic                          irq_clr_o
);
  logic [CNT_W-1:0] shd_half_q, act_half_q;
  logic [DT_W-1:0]  shd_guard_q, act_guard_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_half_q  <= '0;
      shd_guard_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_HALF)  shd_half_q  <= wr_data_i;
      if (wr_addr_i == ADDR_GUARD) shd_guard_q <= wr_data_i[DT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_half_q  <= '0;
      act_guard_q <= '0;
    end else if (load_i) begin
      act_half_q  <= shd_half_q;
      act_guard_q <= shd_guard_q;
    end
  end

  for (genvar g = 0; g < PHASES; g++) begin : g_duty
    localparam logic [REG_ADDR_W-1:0] SEL = ADDR_DUTY0 + REG_ADDR_W'(g);
    logic [CNT_W-1:0] shd_q, act_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shd_q <= '0;
        act_q <= '0;
      end else begin
        if (wr_en_i && wr_addr_i == SEL) shd_q <= wr_data_i;
        if (load_i) act_q <= shd_q;
      end
    end
    assign act_duty_o[g] = act_q;
  end

  assign shd_half_o  = shd_half_q;
  assign act_half_o  = act_half_q;
  assign act_guard_o = act_guard_q;
  assign irq_clr_o   = wr_en_i && (wr_addr_i == ADDR_IRQ_CLR);
endmodule

// File: rtl/pwm3_timebase.sv
module pwm3_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] act_half_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic             load_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             up_q;
  logic             running;

  assign running = act_half_i >= CNT_W'(2);
  assign cnt_inc = cnt_q + CNT_W'(1);
  // wrap on the last down step, or every clock while idle to pick up a legal period
  assign load_o  = !running || (!up_q && cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (load_o) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (up_q) begin
      cnt_q <= cnt_inc;
      if (cnt_inc == act_half_i) up_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o     = cnt_q;
  assign running_o = running;
  assign zero_o    = running && cnt_q == '0;
endmodule

// File: rtl/pwm3_deadband.sv
module pwm3_deadband #(
  parameter int HOLD_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raw_i,
  input  logic [HOLD_W-1:0] lim_i,
  output logic              gate_o
);
  logic [HOLD_W-1:0] hold_q;
  logic              gate_q;

  // hold_q: consecutive earlier clocks with raw_i high, saturating above any limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      gate_q <= 1'b0;
    end else begin
      gate_q <= raw_i && (hold_q >= lim_i);
      if (!raw_i)            hold_q <= '0;
      else if (hold_q != '1) hold_q <= hold_q + HOLD_W'(1);
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/pwm3_center.sv
module pwm3_center
  import pwm3_pkg::*;
#(
  parameter int PHASES = 3,
  parameter int CNT_W  = 16,
  parameter int DT_W   = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]      wr_data_i,
  output logic [PHASES-1:0]     gate_hi_o,
  output logic [PHASES-1:0]     gate_lo_o,
  output logic                  sync_o,
  output logic                  sync_irq_o
);
  localparam int HOLD_W = DT_W + 1;

  logic [CNT_W-1:0]             shd_half, act_half, cnt;
  logic [DT_W-1:0]              act_guard;
  logic [PHASES-1:0][CNT_W-1:0] act_duty;
  logic                         running, load, at_zero, irq_clr;
  logic [HOLD_W-1:0]            guard_lim;
  logic [PHASES-1:0]            raw_hi, raw_lo;
  logic                         sync_q, irq_q;

  pwm3_regs #(.PHASES(PHASES), .CNT_W(CNT_W), .DT_W(DT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_i(load), .shd_half_o(shd_half), .act_half_o(act_half),
    .act_guard_o(act_guard), .act_duty_o(act_duty), .irq_clr_o(irq_clr)
  );

  pwm3_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i, .rst_ni, .act_half_i(act_half),
    .cnt_o(cnt), .running_o(running), .load_o(load), .zero_o(at_zero)
  );

  assign guard_lim = {act_guard, 1'b0};

  for (genvar g = 0; g < PHASES; g++) begin : g_phase
    logic below;
    assign below     = cnt < act_duty[g];
    assign raw_hi[g] = running && below;
    assign raw_lo[g] = running && !below;

    pwm3_deadband #(.HOLD_W(HOLD_W)) u_db_hi (
      .clk_i, .rst_ni, .raw_i(raw_hi[g]), .lim_i(guard_lim), .gate_o(gate_hi_o[g])
    );
    pwm3_deadband #(.HOLD_W(HOLD_W)) u_db_lo (
      .clk_i, .rst_ni, .raw_i(raw_lo[g]), .lim_i(guard_lim), .gate_o(gate_lo_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      sync_q <= at_zero;
      if (at_zero)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  assign sync_o     = sync_q;
  assign sync_irq_o = irq_q;
endmodule

// File: rtl/pwm3_center_chk.sv
module pwm3_center_chk #(
  parameter int PHASES = 3,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PHASES-1:0] gate_hi_o,
  input logic [PHASES-1:0] gate_lo_o,
  input logic              sync_o,
  input logic              sync_irq_o,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  act_half,
  input logic              running
);
  // R7
  no_shoot_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_hi_o & gate_lo_o) == '0);

  // R2
  sync_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |-> cnt <= act_half);

  // R3
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |=> (gate_hi_o == '0 && gate_lo_o == '0 && !sync_o));

  // R8
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> sync_irq_o);
endmodule

bind pwm3_center pwm3_center_chk #(.PHASES(PHASES), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o),
  .sync_o(sync_o), .sync_irq_o(sync_irq_o), .cnt(cnt), .act_half(act_half),
  .running(running)
);

// File: tb/pwm3_center_test.sv
module pwm3_center_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  hi, lo;
  logic        sync, irq;

  always #4 clk = ~clk;

  pwm3_center uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .gate_hi_o(hi), .gate_lo_o(lo), .sync_o(sync),
    .sync_irq_o(irq)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model, advanced on every rising edge
  int m_cnt, m_per, m_guard, s_per, s_guard;
  int m_duty[3], s_duty[3], hold_h[3], hold_l[3];
  bit m_up, e_sync, e_irq, run, rh, rl, zero_now;
  logic [2:0] e_hi, e_lo;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_guard = 0; s_per = 0; s_guard = 0; m_up = 1;
      e_sync = 0; e_irq = 0; e_hi = '0; e_lo = '0;
      for (int i = 0; i < 3; i++) begin
        m_duty[i] = 0; s_duty[i] = 0; hold_h[i] = 0; hold_l[i] = 0;
      end
    end else begin
      run = m_per >= 2;
      for (int i = 0; i < 3; i++) begin
        rh = run && (m_cnt < m_duty[i]);
        rl = run && !(m_cnt < m_duty[i]);
        e_hi[i] = rh && (hold_h[i] >= 2 * m_guard);
        e_lo[i] = rl && (hold_l[i] >= 2 * m_guard);
        hold_h[i] = rh ? hold_h[i] + 1 : 0;
        hold_l[i] = rl ? hold_l[i] + 1 : 0;
      end
      zero_now = run && m_cnt == 0;
      if (zero_now) e_irq = 1;
      else if (wr_en && wr_addr == 3'd5) e_irq = 0;
      e_sync = zero_now;
      if (!run || (!m_up && m_cnt == 1)) begin
        m_cnt = 0; m_up = 1; m_per = s_per; m_guard = s_guard;
        for (int i = 0; i < 3; i++) m_duty[i] = s_duty[i];
      end else if (m_up) begin
        m_cnt++;
        if (m_cnt == m_per) m_up = 0;
      end else begin
        m_cnt--;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: s_per = int'(wr_data);
          3'd1: s_guard = int'(wr_data[9:0]);
          3'd2, 3'd3, 3'd4: s_duty[wr_addr - 3'd2] = int'(wr_data);
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(hi === e_hi, "R4 gate_hi cycle", int'(hi), int'(e_hi));
      chk(lo === e_lo, "R5 gate_lo cycle", int'(lo), int'(e_lo));
      chk(sync === e_sync, "R2 sync cycle", int'(sync), int'(e_sync));
      chk(irq === e_irq, "R8 irq cycle", int'(irq), int'(e_irq));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_sync();
    do @(negedge clk); while (sync !== 1'b1);
  endtask

  task automatic cfg(input int p, input int g, input int d0, input int d1, input int d2);
    wr(0, p); wr(1, g); wr(2, d0); wr(3, d1); wr(4, d2);
  endtask

  function automatic int exp_hi_w(input int p, input int g, input int d);
    int w;
    if (d == 0) return 0;
    if (d > p) return 2 * p;
    w = 2 * d - 1 - 2 * g;
    return (w < 0) ? 0 : w;
  endfunction

  function automatic int exp_lo_w(input int p, input int g, input int d);
    int w;
    if (d == 0) return 2 * p;
    if (d > p) return 0;
    w = 2 * p - 2 * d + 1 - 2 * g;
    return (w < 0) ? 0 : w;
  endfunction

  task automatic measure(input int p, input int g, input int d0, input int d1, input int d2);
    int cyc, duty[3], hc[3], lc[3], bc[3];
    duty[0] = d0; duty[1] = d1; duty[2] = d2;
    for (int i = 0; i < 3; i++) begin hc[i] = 0; lc[i] = 0; bc[i] = 0; end
    repeat (3) wait_sync();
    cyc = 0;
    do begin
      for (int i = 0; i < 3; i++) begin
        hc[i] += int'(hi[i]);
        lc[i] += int'(lo[i]);
        bc[i] += int'(!hi[i] && !lo[i]);
      end
      cyc++;
      @(negedge clk);
    end while (sync !== 1'b1);
    chk(cyc == 2 * p, "R2 period length", cyc, 2 * p);
    for (int i = 0; i < 3; i++) begin
      chk(hc[i] == exp_hi_w(p, g, duty[i]), "R4 high width", hc[i], exp_hi_w(p, g, duty[i]));
      chk(lc[i] == exp_lo_w(p, g, duty[i]), "R5 low width", lc[i], exp_lo_w(p, g, duty[i]));
      chk(bc[i] == 2 * p - exp_hi_w(p, g, duty[i]) - exp_lo_w(p, g, duty[i]),
          "R6 guard gap", bc[i], 2 * p - exp_hi_w(p, g, duty[i]) - exp_lo_w(p, g, duty[i]));
    end
  endtask

  task automatic quiet_window(input int n);
    int act;
    act = 0;
    repeat (n) begin
      @(negedge clk);
      act += int'(sync) + int'(hi != 0) + int'(lo != 0);
    end
    chk(act == 0, "R3 idle outputs", act, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk({hi, lo, sync, irq} == '0, "R9 reset outputs", int'({hi, lo, sync, irq}), 0);
    rst_n = 1'b1;
    quiet_window(20);
    wr(0, 1);
    quiet_window(20);

    cfg(10, 1, 4, 6, 9);
    measure(10, 1, 4, 6, 9);
    cfg(20, 3, 10, 0, 25);
    measure(20, 3, 10, 0, 25);
    cfg(7, 0, 3, 5, 7);
    measure(7, 0, 3, 5, 7);

    // R1: mid-period period write leaves current period alone
    wait_sync();
    repeat (3) @(negedge clk);
    wr(0, 12);
    cyc = 5;
    while (sync !== 1'b1) begin @(negedge clk); cyc++; end
    chk(cyc == 14, "R1 held write", cyc, 14);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (sync !== 1'b1);
    chk(cyc == 24, "R2 new period", cyc, 24);

    // R8 interrupt set and clear
    chk(irq == 1'b1, "R8 irq set", int'(irq), 1);
    repeat (2) @(negedge clk);
    wr(5, 0);
    chk(irq == 1'b0, "R8 irq clear", int'(irq), 0);
    wait_sync();
    chk(irq == 1'b1, "R8 irq reset by sync", int'(irq), 1);

    // R3 illegal period while running stops at the next wrap
    wr(0, 0);
    repeat (30) @(negedge clk);
    quiet_window(40);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule